// File: doc/BRIEF.md
# Power-Save Mode Clock Controller

This block moves a microcontroller core between four operating states: running, halted, idle and stopped. It drives the enables for the core clock, for the internal system clock that feeds the peripherals and for the clock generator. It also sequences the restart wait after the generator has been switched off. A halted core keeps its peripherals clocked. An idle core stops both clocks but leaves the generator running, so it restarts at once. A stopped core switches the generator off, and its restart holds every clock gated for a programmable settling time.

The halt instruction arrives as a one-cycle strobe. The idle and stop requests arrive as a register write that carries a two-bit power-save code. Any interrupt request whose mask bit is clear wakes the core. The length of the restart wait after a stop depends on two inputs: whether the generator is working through its PLL or feeding the clock directly, and whether an external clock replaces the crystal. While a wait is counting down, a busy flag is raised. A separate inhibit input can shut off the clock output pin. All outputs come from registers, so they change only on rising clock edges.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is asserted, cpu_clk_en, sys_clk_en and clkout_en are 0, and osc_en and stab_busy are 1. After reset is released, the block applies the same restart wait it applies when leaving stop (R5 to R8), and then enters the running state.
- R2: In the running state, a high halt_strobe stops only the core clock from the next edge: cpu_clk_en=0, sys_clk_en=1, osc_en=1. An unmasked interrupt returns the block to running on the following edge.
- R3: In the running state, a write (ps_wr=1) with ps_code=01 enters idle: cpu_clk_en=0, sys_clk_en=0, osc_en=1, stab_busy=0. An unmasked interrupt returns the block to running on the next edge, with no busy period.
- R4: In the running state, a write with ps_code=10 enters stop: cpu_clk_en, sys_clk_en, osc_en and stab_busy are all 0.
- R5: When the block wakes from stop with ext_clk_sel=0, it spends one decision cycle and then osc_wait_reload+1 cycles of oscillator wait, all with stab_busy=1, osc_en=1 and both clock enables 0. The core clock therefore returns osc_wait_reload+2 edges after the decision cycle.
- R6: When pll_sel=1 and lock_wait_en=1, a lock wait of lock_wait_reload+1 cycles follows the oscillator wait, and stab_busy stays 1 during it.
- R7: When ext_clk_sel=1, the oscillator wait is skipped. With no lock wait as well, the block is running on the edge after the decision cycle.
- R8: When pll_sel=0, no lock wait is applied, even if lock_wait_en=1.
- R9: A wake-up comes only from an irq_req bit whose irq_mask bit is 0. Mask bit 1 blocks that request, and an interrupt has no effect in the running state.
- R10: Codes 00 (no change) and 11 (reserved) are ignored. Writes and halt strobes outside the running state are ignored. A write of 01 or 10 takes priority over a halt strobe in the same cycle. A write acts once and need not be cleared.
- R11: clkout_en equals the registered value of (system clock enabled next AND NOT clkout_inhibit). It changes on the same edge as sys_clk_en, and one edge after clkout_inhibit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_strobe | input | 1 | One-cycle halt instruction pulse |
| ps_wr | input | 1 | Power-save register write strobe |
| ps_code | input | 2 | Written code: 00 keep, 01 idle, 10 stop, 11 reserved |
| irq_req | input | NUM_IRQ | Interrupt / wake-up requests |
| irq_mask | input | NUM_IRQ | 1 = request masked |
| pll_sel | input | 1 | 1 = PLL mode, 0 = direct mode |
| ext_clk_sel | input | 1 | 1 = external clock, no oscillator wait |
| lock_wait_en | input | 1 | Enables the PLL lock wait |
| osc_wait_reload | input | CNT_W | Oscillator wait reload value |
| lock_wait_reload | input | CNT_W | Lock wait reload value |
| clkout_inhibit | input | 1 | Disables the clock output pin |
| cpu_clk_en | output | 1 | Core clock enable |
| sys_clk_en | output | 1 | Peripheral system clock enable |
| osc_en | output | 1 | Clock generator enable |
| stab_busy | output | 1 | Restart wait in progress |
| clkout_en | output | 1 | Clock output pin enable |

## Verification
Every output is a register that loads from the next-state decode, so a strobe or interrupt sampled on one edge shows its effect on the outputs right after that same edge. The bench drives inputs at the falling edge and reads the outputs one time unit after the following rising edge. A stop release takes a known number of edges, counted from the edge that samples the wake request: 2 with no waits, osc_wait_reload+3 with the oscillator wait only, and one more plus lock_wait_reload when the lock wait is added. The bench counts rising edges until cpu_clk_en returns, checks that this count matches exactly, and checks that stab_busy was high on every edge before it. clkout_en is checked on the edge after clkout_inhibit changes.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_HALT = 3'd1,
    ST_IDLE = 3'd2,
    ST_STOP = 3'd3,
    ST_REL  = 3'd4,
    ST_OSC  = 3'd5,
    ST_LOCK = 3'd6
  } pm_state_e;

  localparam logic [1:0] PS_IDLE = 2'b01;
  localparam logic [1:0] PS_STOP = 2'b10;

  typedef struct packed {
    logic cpu;
    logic sys;
    logic osc;
    logic busy;
  } clk_ctl_t;

  function automatic clk_ctl_t ctl_of(pm_state_e s);
    clk_ctl_t c;
    unique case (s)
      ST_RUN:  c = '{cpu: 1'b1, sys: 1'b1, osc: 1'b1, busy: 1'b0};
      ST_HALT: c = '{cpu: 1'b0, sys: 1'b1, osc: 1'b1, busy: 1'b0};
      ST_IDLE: c = '{cpu: 1'b0, sys: 1'b0, osc: 1'b1, busy: 1'b0};
      ST_STOP: c = '{cpu: 1'b0, sys: 1'b0, osc: 1'b0, busy: 1'b0};
      default: c = '{cpu: 1'b0, sys: 1'b0, osc: 1'b1, busy: 1'b1};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pmc_wait_cnt.sv
module pmc_wait_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (load)              cnt_q <= load_val;
    else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
  import pmc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_strobe,
  input  logic             ps_wr,
  input  logic [1:0]       ps_code,
  input  logic             wake,
  input  logic             pll_sel,
  input  logic             ext_clk_sel,
  input  logic             lock_wait_en,
  input  logic [CNT_W-1:0] osc_wait_reload,
  input  logic [CNT_W-1:0] lock_wait_reload,
  output pm_state_e        state_nxt
);

  pm_state_e        state_q;
  logic             need_osc, need_lock;
  logic             cnt_load, cnt_dec, cnt_done;
  logic [CNT_W-1:0] cnt_val;

  assign need_osc  = !ext_clk_sel;
  assign need_lock = pll_sel && lock_wait_en;

  always_comb begin
    state_nxt = state_q;
    cnt_load  = 1'b0;
    cnt_dec   = 1'b0;
    cnt_val   = osc_wait_reload;
    unique case (state_q)
      ST_RUN: begin
        if (ps_wr && ps_code == PS_IDLE)      state_nxt = ST_IDLE;
        else if (ps_wr && ps_code == PS_STOP) state_nxt = ST_STOP;
        else if (halt_strobe)                 state_nxt = ST_HALT;
      end
      ST_HALT, ST_IDLE: if (wake) state_nxt = ST_RUN;
      ST_STOP:          if (wake) state_nxt = ST_REL;
      ST_REL: begin
        if (need_osc) begin
          state_nxt = ST_OSC;
          cnt_load  = 1'b1;
        end else if (need_lock) begin
          state_nxt = ST_LOCK;
          cnt_load  = 1'b1;
          cnt_val   = lock_wait_reload;
        end else begin
          state_nxt = ST_RUN;
        end
      end
      ST_OSC: begin
        if (!cnt_done) begin
          cnt_dec = 1'b1;
        end else if (need_lock) begin
          state_nxt = ST_LOCK;
          cnt_load  = 1'b1;
          cnt_val   = lock_wait_reload;
        end else begin
          state_nxt = ST_RUN;
        end
      end
      ST_LOCK: begin
        if (!cnt_done) cnt_dec = 1'b1;
        else           state_nxt = ST_RUN;
      end
      default: state_nxt = ST_REL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_REL;
    else        state_q <= state_nxt;
  end

  pmc_wait_cnt #(.CNT_W(CNT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .dec      (cnt_dec),
    .done     (cnt_done)
  );

endmodule

// File: rtl/pmc_gate.sv
module pmc_gate
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pm_state_e state_nxt,
  input  logic      clkout_inhibit,
  output logic      cpu_clk_en,
  output logic      sys_clk_en,
  output logic      osc_en,
  output logic      stab_busy,
  output logic      clkout_en
);

  clk_ctl_t ctl_nxt, ctl_q;

  assign ctl_nxt = ctl_of(state_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= ctl_of(ST_REL);
      clkout_en <= 1'b0;
    end else begin
      ctl_q     <= ctl_nxt;
      clkout_en <= ctl_nxt.sys && !clkout_inhibit;
    end
  end

  assign cpu_clk_en = ctl_q.cpu;
  assign sys_clk_en = ctl_q.sys;
  assign osc_en     = ctl_q.osc;
  assign stab_busy  = ctl_q.busy;

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt_strobe,
  input  logic               ps_wr,
  input  logic [1:0]         ps_code,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_mask,
  input  logic               pll_sel,
  input  logic               ext_clk_sel,
  input  logic               lock_wait_en,
  input  logic [CNT_W-1:0]   osc_wait_reload,
  input  logic [CNT_W-1:0]   lock_wait_reload,
  input  logic               clkout_inhibit,
  output logic               cpu_clk_en,
  output logic               sys_clk_en,
  output logic               osc_en,
  output logic               stab_busy,
  output logic               clkout_en
);

  logic      wake_req;
  pm_state_e state_nxt;

  assign wake_req = |(irq_req & ~irq_mask);

  pmc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk              (clk),
    .rst_n            (rst_n),
    .halt_strobe      (halt_strobe),
    .ps_wr            (ps_wr),
    .ps_code          (ps_code),
    .wake             (wake_req),
    .pll_sel          (pll_sel),
    .ext_clk_sel      (ext_clk_sel),
    .lock_wait_en     (lock_wait_en),
    .osc_wait_reload  (osc_wait_reload),
    .lock_wait_reload (lock_wait_reload),
    .state_nxt        (state_nxt)
  );

  pmc_gate u_gate (
    .clk            (clk),
    .rst_n          (rst_n),
    .state_nxt      (state_nxt),
    .clkout_inhibit (clkout_inhibit),
    .cpu_clk_en     (cpu_clk_en),
    .sys_clk_en     (sys_clk_en),
    .osc_en         (osc_en),
    .stab_busy      (stab_busy),
    .clkout_en      (clkout_en)
  );

endmodule

// File: rtl/pmc_chk.sv
module pmc_chk #(
  parameter int NUM_IRQ = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_IRQ-1:0] irq_req,
  input logic [NUM_IRQ-1:0] irq_mask,
  input logic               clkout_inhibit,
  input logic               cpu_clk_en,
  input logic               sys_clk_en,
  input logic               osc_en,
  input logic               stab_busy,
  input logic               clkout_en
);

  logic wake, idle_now;
  assign wake     = |(irq_req & ~irq_mask);
  assign idle_now = !sys_clk_en && osc_en && !stab_busy;

  AST_CPU_NEEDS_SYS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> sys_clk_en);                                   // R2
  AST_STOP_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (!cpu_clk_en && !sys_clk_en && !stab_busy));      // R4
  AST_BUSY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    stab_busy |-> (!cpu_clk_en && !sys_clk_en && osc_en));        // R5
  AST_IDLE_FAST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_now && wake) |=> (cpu_clk_en && !stab_busy));           // R3
  AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_now && !wake) |=> idle_now);                            // R9
  AST_STOP_WAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && wake) |=> stab_busy);                             // R5
  AST_CLKOUT_SYS: assert property (@(posedge clk) disable iff (!rst_n)
    clkout_en |-> sys_clk_en);                                    // R11
  AST_CLKOUT_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clkout_inhibit) |-> !clkout_en);                        // R11

endmodule

bind pwr_mode_ctrl pmc_chk #(.NUM_IRQ(NUM_IRQ)) u_pmc_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .irq_req        (irq_req),
  .irq_mask       (irq_mask),
  .clkout_inhibit (clkout_inhibit),
  .cpu_clk_en     (cpu_clk_en),
  .sys_clk_en     (sys_clk_en),
  .osc_en         (osc_en),
  .stab_busy      (stab_busy),
  .clkout_en      (clkout_en)
);

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_IRQ    = 8;
  localparam int CNT_W      = 16;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               halt_strobe = 1'b0, ps_wr = 1'b0;
  logic [1:0]         ps_code = 2'b00;
  logic [NUM_IRQ-1:0] irq_req = '0;
  logic [NUM_IRQ-1:0] irq_mask = 8'b0000_0010;
  logic               pll_sel = 1'b1, ext_clk_sel = 1'b0, lock_wait_en = 1'b1;
  logic [CNT_W-1:0]   osc_wait_reload = 16'd3, lock_wait_reload = 16'd2;
  logic               clkout_inhibit = 1'b0;
  logic               cpu_clk_en, sys_clk_en, osc_en, stab_busy, clkout_en;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.NUM_IRQ(NUM_IRQ), .CNT_W(CNT_W)) i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .halt_strobe(halt_strobe), .ps_wr(ps_wr),
    .ps_code(ps_code), .irq_req(irq_req), .irq_mask(irq_mask),
    .pll_sel(pll_sel), .ext_clk_sel(ext_clk_sel), .lock_wait_en(lock_wait_en),
    .osc_wait_reload(osc_wait_reload), .lock_wait_reload(lock_wait_reload),
    .clkout_inhibit(clkout_inhibit), .cpu_clk_en(cpu_clk_en),
    .sys_clk_en(sys_clk_en), .osc_en(osc_en), .stab_busy(stab_busy),
    .clkout_en(clkout_en)
  );

  // Vector: [9]halt [8]wr [7:6]code [5]irq0 (unmasked) [4]irq1 (masked)
  //         [3:0] expected {cpu, sys, osc, busy}
  localparam int NVEC = 15;
  localparam logic [9:0] VEC [NVEC] = '{
    10'b1_0_00_00_0110,  // R2 halt strobe
    10'b0_0_00_00_0110,  // R2 stays halted
    10'b0_1_01_00_0110,  // R10 write ignored while halted
    10'b0_0_00_10_1110,  // R2 interrupt resumes
    10'b0_1_11_00_1110,  // R10 reserved code ignored
    10'b0_1_00_00_1110,  // R10 keep code ignored
    10'b1_1_01_00_0010,  // R10 write beats halt -> idle (R3)
    10'b0_0_00_01_0010,  // R9 masked request no wake
    10'b1_0_00_00_0010,  // R10 halt ignored in idle
    10'b0_0_00_10_1110,  // R3 wake from idle, no busy
    10'b0_0_00_10_1110,  // R9 interrupt in run has no effect
    10'b0_1_10_00_0000,  // R4 stop
    10'b0_0_00_01_0000,  // R9 masked request keeps stop
    10'b0_0_00_10_0011,  // R7 decision cycle after wake
    10'b0_0_00_00_1110   // R7 external clock: no waits
  };
  localparam int VREQ [NVEC] = '{2, 2, 10, 2, 10, 10, 10, 9, 10, 3, 9, 4, 9, 7, 7};

  function automatic logic [3:0] outs();
    return {cpu_clk_en, sys_clk_en, osc_en, stab_busy};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic stop_release(input logic pll, input logic ext, input logic len,
                              input int osc, input int lock, input int exp_n,
                              input string req);
    int n;
    @(negedge clk);
    pll_sel = pll; ext_clk_sel = ext; lock_wait_en = len;
    osc_wait_reload = CNT_W'(osc); lock_wait_reload = CNT_W'(lock);
    ps_wr = 1'b1; ps_code = 2'b10;
    @(posedge clk); #1;
    check(outs() == 4'b0000, req, outs(), 4'b0000);
    @(negedge clk);
    ps_wr = 1'b0; ps_code = 2'b00; irq_req = 8'h01;
    n = 0;
    for (int k = 0; k < 200; k++) begin
      @(posedge clk); #1;
      n++;
      if (cpu_clk_en) break;
      if (!stab_busy) begin
        check(1'b0, req, {28'd0, outs()}, 4'b0011);
        break;
      end
    end
    check(n == exp_n && cpu_clk_en, req, n, exp_n);
    @(negedge clk);
    irq_req = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check(outs() == 4'b0011 && !clkout_en, "R1 reset",
          {outs(), clkout_en}, 5'b00110);
    // R1: release with osc=3, lock=2 in PLL mode -> running on edge 8
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    for (int k = 0; k < 100; k++) begin
      @(posedge clk); #1;
      n++;
      if (cpu_clk_en) break;
    end
    check(n == 8, "R1 reset wait length", n, 8);

    // table walk: external clock, direct mode
    @(negedge clk);
    ext_clk_sel = 1'b1; pll_sel = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      halt_strobe = VEC[i][9];
      ps_wr       = VEC[i][8];
      ps_code     = VEC[i][7:6];
      irq_req     = {6'd0, VEC[i][4], VEC[i][5]};
      @(posedge clk); #1;
      check(outs() == VEC[i][3:0], $sformatf("R%0d vector %0d", VREQ[i], i),
            outs(), VEC[i][3:0]);
    end
    @(negedge clk);
    halt_strobe = 1'b0; ps_wr = 1'b0; ps_code = 2'b00; irq_req = '0;

    // R11: clock output inhibit
    clkout_inhibit = 1'b1;
    @(posedge clk); #1;
    check(!clkout_en && sys_clk_en, "R11 inhibit", clkout_en, 0);
    @(negedge clk);
    clkout_inhibit = 1'b0;
    @(posedge clk); #1;
    check(clkout_en, "R11 release inhibit", clkout_en, 1);
    @(negedge clk);
    ps_wr = 1'b1; ps_code = 2'b01;
    @(posedge clk); #1;
    check(!clkout_en, "R11 idle gates clkout", clkout_en, 0);
    @(negedge clk);
    ps_wr = 1'b0; ps_code = 2'b00; irq_req = 8'h01;
    @(posedge clk); #1;
    check(clkout_en && cpu_clk_en, "R11 clkout back with run", clkout_en, 1);
    @(negedge clk);
    irq_req = '0;

    // stop release timing
    stop_release(1'b1, 1'b0, 1'b0, 5, 0, 8,  "R5 osc wait only");
    stop_release(1'b1, 1'b0, 1'b1, 4, 3, 11, "R6 osc plus lock wait");
    stop_release(1'b1, 1'b1, 1'b1, 0, 6, 9,  "R7 external clock, lock only");
    stop_release(1'b0, 1'b0, 1'b1, 2, 9, 5,  "R8 direct mode, no lock");
    stop_release(1'b0, 1'b1, 1'b0, 7, 7, 2,  "R7 external direct, no waits");

    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule